// File: doc/BRIEF.md
# Counted-Burst DMA Request Engine

This block runs the device side of a request/acknowledge DMA link for one endpoint buffer at a time. Software first sets up the transfer:

- a byte count;
- a burst length in bus cycles;
- a bus width of 16 or 32 bits;
- the active level of the request and acknowledge pins;
- the endpoint to serve.

Software then issues a read or a write start. The engine raises its request pin for one burst. It counts each acknowledged bus cycle against the burst and against the remaining byte count. It drops the request for one cycle between bursts. When the byte count runs out, it stops and reports success.

The count can only be run down by a transfer counter. A configuration bit that disables this counter blocks every start. While a transfer is active, the chosen endpoint buffer is routed to the DMA side, and each accepted cycle pops it (read direction) or pushes into it (write direction). A chip-select access that coincides with an acknowledge is flagged as an error and the cycle is dropped. A software abort returns the engine to idle at once.

Top module: `dmahs_engine`

## Requirements
- R1: After reset, `busy`, `xfer_ok`, `xfer_err` and `irq` are 0, `ep_route` is all zero, and `dreq` sits at its inactive level.
- R2: In idle, a pulse on `cmd_rd_go` or `cmd_wr_go` starts a transfer on the next clock edge, but only when `cfg_cnt_off` is 0 and `cfg_byte_cnt` is nonzero. If both pulses arrive together, the transfer is a read. Otherwise the start is ignored and `busy` stays 0.
- R3: Each accepted cycle removes 4 bytes when `cfg_wide` is 1, or 2 bytes when it is 0. A remainder smaller than one word is moved as one final cycle. The number of accepted cycles is therefore count/step, rounded up.
- R4: `dreq` stays active for `cfg_burst` accepted cycles, with 0 treated as 1. If bytes remain after a burst, `dreq` goes inactive for exactly one cycle and is then raised again. With a burst of 1, `dreq` toggles every cycle. An acknowledge while `dreq` is inactive is ignored.
- R5: When `cfg_req_lo` is 1, `dreq` is active low; otherwise it is active high. When `cfg_ack_lo` is 1, `dack` is active low; otherwise it is active high.
- R6: On the clock edge that accepts the final cycle, `busy` falls and `xfer_ok` rises. `xfer_ok` stays set until the next start or abort.
- R7: `irq` equals `xfer_ok` AND `ien_glb` AND `ien_dma`, as a level.
- R8: If `cs_act` is high in a requesting cycle with `dack` active, `xfer_err` is set and the cycle is ignored: no pop, no push, no count. A new start clears `xfer_err`.
- R9: `cmd_abort` sends the engine to idle on the next edge with `dreq` inactive and `xfer_ok` clear. Any acknowledge in that same cycle is ignored.
- R10: While `busy`, `ep_route` is one-hot at bit `cfg_ep`, latched at start; in idle it is zero. On an accepted cycle:
  - a read asserts `buf_pop` and passes `buf_rdata` to `dma_rdata`;
  - a write asserts `buf_push` and passes `dma_wdata` to `buf_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_cnt_off | input | 1 | Counter disable; 1 blocks starts |
| cfg_byte_cnt | input | CNT_W | Byte count loaded at start |
| cfg_burst | input | BURST_W | Cycles per burst (0 acts as 1) |
| cfg_wide | input | 1 | 1 = 32-bit bus, 0 = 16-bit bus |
| cfg_req_lo | input | 1 | Request pin active low |
| cfg_ack_lo | input | 1 | Acknowledge pin active low |
| cfg_ep | input | EP_W | Endpoint to route to DMA |
| ien_glb | input | 1 | Global interrupt enable |
| ien_dma | input | 1 | DMA interrupt enable |
| cmd_rd_go | input | 1 | Start read (buffer to bus) |
| cmd_wr_go | input | 1 | Start write (bus to buffer) |
| cmd_abort | input | 1 | Abort to idle |
| dreq | output | 1 | DMA request pin |
| dack | input | 1 | DMA acknowledge pin |
| cs_act | input | 1 | Chip-select access in progress |
| dma_wdata | input | DATA_W | Bus data for writes |
| dma_rdata | output | DATA_W | Bus data for reads |
| buf_rdata | input | DATA_W | Buffer head word |
| buf_wdata | output | DATA_W | Word pushed into buffer |
| buf_pop | output | 1 | Pop strobe to buffer |
| buf_push | output | 1 | Push strobe to buffer |
| ep_route | output | NUM_EP | One-hot endpoint routed to DMA |
| busy | output | 1 | Transfer in progress |
| xfer_ok | output | 1 | Transfer completed by count |
| xfer_err | output | 1 | Chip-select collision seen |
| irq | output | 1 | Completion interrupt |

## Verification
A wrong remaining-byte value shows at the ports as a cycle count that is off at the end of the run, so it is caught only when `busy` falls. A wrong burst counter shows much sooner, at the first release of `dreq`, as a burst that is too long or too short. A missing one-cycle gap is visible in the very next cycle. A lost or doubled data word appears at once on the buffer strobes, where the scoreboard compares each one against the word the bench drove.

// File: rtl/dmahs_pkg.sv
package dmahs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_GAP  = 2'd2
    } dh_state_e;
endpackage

// File: rtl/dmahs_pol.sv
// Level adapter: flips each bit whose invert flag is set.
module dmahs_pol #(
    parameter int W = 1
) (
    input  logic [W-1:0] raw,
    input  logic [W-1:0] inv,
    output logic [W-1:0] pin
);
    assign pin = raw ^ inv;
endmodule

// File: rtl/dmahs_bytecnt.sv
// Byte countdown step: removes one bus word, clamping a short tail to zero.
module dmahs_bytecnt #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] left,
    input  logic             wide,
    output logic [CNT_W-1:0] left_after,
    output logic             last
);
    logic [CNT_W-1:0] step;

    always_comb begin
        step       = wide ? CNT_W'(4) : CNT_W'(2);
        last       = (left <= step);
        left_after = last ? '0 : (left - step);
    end
endmodule

// File: rtl/dmahs_route.sv
// One-hot endpoint selector for the DMA data path.
module dmahs_route #(
    parameter int NUM_EP = 8,
    parameter int EP_W   = 3
) (
    input  logic              en,
    input  logic [EP_W-1:0]   sel,
    output logic [NUM_EP-1:0] hot
);
    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        assign hot[i] = en && (sel == EP_W'(i));
    end
endmodule

// File: rtl/dmahs_engine.sv
module dmahs_engine
    import dmahs_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int BURST_W = 8,
    parameter int NUM_EP  = 8,
    parameter int DATA_W  = 32,
    localparam int EP_W   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_cnt_off,
    input  logic [CNT_W-1:0]    cfg_byte_cnt,
    input  logic [BURST_W-1:0]  cfg_burst,
    input  logic                cfg_wide,
    input  logic                cfg_req_lo,
    input  logic                cfg_ack_lo,
    input  logic [EP_W-1:0]     cfg_ep,
    input  logic                ien_glb,
    input  logic                ien_dma,
    input  logic                cmd_rd_go,
    input  logic                cmd_wr_go,
    input  logic                cmd_abort,
    output logic                dreq,
    input  logic                dack,
    input  logic                cs_act,
    input  logic [DATA_W-1:0]   dma_wdata,
    output logic [DATA_W-1:0]   dma_rdata,
    input  logic [DATA_W-1:0]   buf_rdata,
    output logic [DATA_W-1:0]   buf_wdata,
    output logic                buf_pop,
    output logic                buf_push,
    output logic [NUM_EP-1:0]   ep_route,
    output logic                busy,
    output logic                xfer_ok,
    output logic                xfer_err,
    output logic                irq
);
    typedef struct packed {
        dh_state_e          st;
        logic [CNT_W-1:0]   left;
        logic [BURST_W-1:0] bcnt;
        logic [BURST_W-1:0] blen;
        logic               wide;
        logic               rd;
        logic [EP_W-1:0]    ep;
        logic               ok;
        logic               err;
    } regs_t;

    regs_t q, d;

    logic             ack_on;
    logic             req_on;
    logic             beat;
    logic             collide;
    logic [CNT_W-1:0] left_after;
    logic             last_beat;

    // Pin level adaptation
    dmahs_pol #(.W(1)) u_ack_pol (
        .raw (dack),
        .inv (cfg_ack_lo),
        .pin (ack_on)
    );

    assign req_on = (q.st == ST_REQ);

    dmahs_pol #(.W(1)) u_req_pol (
        .raw (req_on),
        .inv (cfg_req_lo),
        .pin (dreq)
    );

    dmahs_bytecnt #(.CNT_W(CNT_W)) u_cnt (
        .left       (q.left),
        .wide       (q.wide),
        .left_after (left_after),
        .last       (last_beat)
    );

    assign collide = req_on && ack_on && cs_act;
    assign beat    = req_on && ack_on && !cs_act && !cmd_abort;

    always_comb begin
        d = q;
        if (collide) begin
            d.err = 1'b1;
        end
        unique case (q.st)
            ST_IDLE: begin
                if ((cmd_rd_go || cmd_wr_go) && !cfg_cnt_off && (cfg_byte_cnt != '0)) begin
                    d.st   = ST_REQ;
                    d.left = cfg_byte_cnt;
                    d.bcnt = '0;
                    d.blen = (cfg_burst == '0) ? BURST_W'(1) : cfg_burst;
                    d.wide = cfg_wide;
                    d.rd   = cmd_rd_go;
                    d.ep   = cfg_ep;
                    d.ok   = 1'b0;
                    d.err  = 1'b0;
                end
            end
            ST_REQ: begin
                if (beat) begin
                    d.left = left_after;
                    if (last_beat) begin
                        d.st   = ST_IDLE;
                        d.ok   = 1'b1;
                        d.bcnt = '0;
                    end else if (q.bcnt + BURST_W'(1) == q.blen) begin
                        d.st   = ST_GAP;
                        d.bcnt = '0;
                    end else begin
                        d.bcnt = q.bcnt + BURST_W'(1);
                    end
                end
            end
            ST_GAP:  d.st = ST_REQ;
            default: d.st = ST_IDLE;
        endcase
        if (cmd_abort) begin
            d.st   = ST_IDLE;
            d.ok   = 1'b0;
            d.bcnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy = (q.st != ST_IDLE);

    dmahs_route #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_route (
        .en  (busy),
        .sel (q.ep),
        .hot (ep_route)
    );

    assign xfer_ok   = q.ok;
    assign xfer_err  = q.err;
    assign irq       = q.ok && ien_glb && ien_dma;
    assign buf_pop   = beat && q.rd;
    assign buf_push  = beat && !q.rd;
    assign buf_wdata = q.rd ? '0 : dma_wdata;
    assign dma_rdata = (busy && q.rd) ? buf_rdata : '0;
endmodule

// File: rtl/dmahs_chk.sv
module dmahs_chk #(
    parameter int NUM_EP = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_cnt_off,
    input logic              cfg_req_lo,
    input logic              cfg_ack_lo,
    input logic              cmd_abort,
    input logic              dreq,
    input logic              dack,
    input logic              cs_act,
    input logic              busy,
    input logic              xfer_ok,
    input logic              xfer_err,
    input logic              irq,
    input logic              buf_pop,
    input logic              buf_push,
    input logic [NUM_EP-1:0] ep_route
);
    AST_IDLE_REQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dreq == cfg_req_lo)); // R1

    AST_OFF_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cfg_cnt_off) |=> !busy); // R2

    AST_BEAT_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_push || buf_pop) |-> (dreq != cfg_req_lo)); // R4

    AST_OK_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_ok) |-> ($past(busy) && !busy)); // R6

    AST_IRQ_NEEDS_OK: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> xfer_ok); // R7

    AST_COLLIDE_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_act |-> (!buf_push && !buf_pop)); // R8

    AST_COLLIDE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (dreq != cfg_req_lo) && (dack != cfg_ack_lo) && cs_act) |=> xfer_err); // R8

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_abort |=> (!busy && !xfer_ok)); // R9

    AST_ROUTE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $onehot(ep_route)); // R10

    AST_ROUTE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ep_route == '0)); // R10

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_push && buf_pop)); // R10
endmodule

bind dmahs_engine dmahs_chk #(.NUM_EP(NUM_EP)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_cnt_off (cfg_cnt_off),
    .cfg_req_lo  (cfg_req_lo),
    .cfg_ack_lo  (cfg_ack_lo),
    .cmd_abort   (cmd_abort),
    .dreq        (dreq),
    .dack        (dack),
    .cs_act      (cs_act),
    .busy        (busy),
    .xfer_ok     (xfer_ok),
    .xfer_err    (xfer_err),
    .irq         (irq),
    .buf_pop     (buf_pop),
    .buf_push    (buf_push),
    .ep_route    (ep_route)
);

// File: tb/sim_dmahs_engine.sv
module sim_dmahs_engine;
    localparam int CNT_W   = 16;
    localparam int BURST_W = 8;
    localparam int NUM_EP  = 8;
    localparam int DATA_W  = 32;
    localparam int EP_W    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_cnt_off = 1'b0;
    logic [CNT_W-1:0] cfg_byte_cnt = '0;
    logic [BURST_W-1:0] cfg_burst = '0;
    logic cfg_wide = 1'b1;
    logic cfg_req_lo = 1'b0;
    logic cfg_ack_lo = 1'b0;
    logic [EP_W-1:0] cfg_ep = '0;
    logic ien_glb = 1'b1;
    logic ien_dma = 1'b1;
    logic cmd_rd_go = 1'b0;
    logic cmd_wr_go = 1'b0;
    logic cmd_abort = 1'b0;
    logic dreq;
    logic dack = 1'b0;
    logic cs_act = 1'b0;
    logic [DATA_W-1:0] dma_wdata = '0;
    logic [DATA_W-1:0] dma_rdata;
    logic [DATA_W-1:0] buf_rdata = '0;
    logic [DATA_W-1:0] buf_wdata;
    logic buf_pop;
    logic buf_push;
    logic [NUM_EP-1:0] ep_route;
    logic busy;
    logic xfer_ok;
    logic xfer_err;
    logic irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    logic [DATA_W-1:0] exp_q[$];

    always #2 clk = ~clk;

    dmahs_engine #(
        .CNT_W(CNT_W), .BURST_W(BURST_W), .NUM_EP(NUM_EP), .DATA_W(DATA_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_cnt_off(cfg_cnt_off), .cfg_byte_cnt(cfg_byte_cnt),
        .cfg_burst(cfg_burst), .cfg_wide(cfg_wide), .cfg_req_lo(cfg_req_lo),
        .cfg_ack_lo(cfg_ack_lo), .cfg_ep(cfg_ep), .ien_glb(ien_glb), .ien_dma(ien_dma),
        .cmd_rd_go(cmd_rd_go), .cmd_wr_go(cmd_wr_go), .cmd_abort(cmd_abort),
        .dreq(dreq), .dack(dack), .cs_act(cs_act), .dma_wdata(dma_wdata),
        .dma_rdata(dma_rdata), .buf_rdata(buf_rdata), .buf_wdata(buf_wdata),
        .buf_pop(buf_pop), .buf_push(buf_push), .ep_route(ep_route), .busy(busy),
        .xfer_ok(xfer_ok), .xfer_err(xfer_err), .irq(irq)
    );

    task automatic chk(input bit good, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!good) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // Scoreboard monitor: pops one expected word per buffer strobe
    always @(negedge clk) begin
        #1;
        if (rst_n && (buf_push || buf_pop)) begin
            if (exp_q.size() == 0) begin
                chk(0, "R10", "strobe with no expected word", 1, 0);
            end else begin
                logic [DATA_W-1:0] e;
                e = exp_q.pop_front();
                if (buf_push) chk(buf_wdata == e, "R10", "write word", buf_wdata, e);
                else          chk(dma_rdata == e, "R10", "read word", dma_rdata, e);
            end
        end
    end

    function automatic logic ack_lvl(input bit act);
        return act ? ~cfg_ack_lo : cfg_ack_lo;
    endfunction

    // Driver: starts a transfer and acknowledges every request cycle
    task automatic run_xfer(input int bytes, input int burst, input bit wide, input bit rd,
                            input int ep, input int coll_at, input int abort_at);
        int step, exp_beats, blen, exp_last, beats, inb, cyc;
        bit gap, errnext, coll_done, aborted, req_on;
        logic [DATA_W-1:0] v;
        step = wide ? 4 : 2;
        exp_beats = (bytes + step - 1) / step;
        blen = (burst == 0) ? 1 : burst;
        exp_last = (exp_beats % blen == 0) ? blen : exp_beats % blen;
        beats = 0; inb = 0; cyc = 0;
        gap = 0; errnext = 0; coll_done = 0; aborted = 0;
        @(negedge clk);
        cfg_byte_cnt = CNT_W'(bytes);
        cfg_burst = BURST_W'(burst);
        cfg_wide = wide;
        cfg_ep = EP_W'(ep);
        cmd_rd_go = rd;
        cmd_wr_go = !rd;
        @(negedge clk);
        cmd_rd_go = 0;
        cmd_wr_go = 0;
        chk(busy == 1, "R2", "busy after start", busy, 1);
        chk(ep_route == NUM_EP'(1 << ep), "R10", "endpoint route", ep_route, 1 << ep);
        chk(xfer_err == 0, "R8", "error cleared by start", xfer_err, 0);
        while (busy && cyc < 400) begin
            cyc++;
            req_on = (dreq !== cfg_req_lo);
            if (errnext) begin
                chk(xfer_err == 1, "R8", "collision flagged", xfer_err, 1);
                chk(req_on, "R8", "request held after ignored cycle", req_on, 1);
                errnext = 0;
            end
            if (gap) begin
                chk(req_on, "R4", "request re-raised after one gap cycle", req_on, 1);
                gap = 0;
            end
            if (abort_at >= 0 && beats == abort_at) begin
                dack = ack_lvl(0);
                cs_act = 0;
                cmd_abort = 1;
                @(negedge clk);
                cmd_abort = 0;
                aborted = 1;
                chk(busy == 0, "R9", "idle after abort", busy, 0);
                chk(xfer_ok == 0, "R9", "ok clear after abort", xfer_ok, 0);
                chk(dreq == cfg_req_lo, "R9", "request inactive after abort", dreq, cfg_req_lo);
                break;
            end
            if (req_on) begin
                if (coll_at == beats && !coll_done) begin
                    dack = ack_lvl(1);
                    cs_act = 1;
                    coll_done = 1;
                    errnext = 1;
                end else begin
                    v = {8'hA5, 8'(ep), 16'(beats)};
                    dack = ack_lvl(1);
                    cs_act = 0;
                    if (rd) buf_rdata = v;
                    else    dma_wdata = v;
                    exp_q.push_back(v);
                    beats++;
                    inb++;
                end
            end else begin
                if (inb > 0) begin
                    chk(inb == blen, "R4", "burst length", inb, blen);
                    gap = 1;
                    inb = 0;
                end
                dack = ack_lvl(0);
                cs_act = 0;
            end
            @(negedge clk);
        end
        dack = ack_lvl(0);
        cs_act = 0;
        if (!aborted) begin
            chk(beats == exp_beats, "R3", "accepted cycles", beats, exp_beats);
            chk(inb == exp_last, "R4", "final burst length", inb, exp_last);
            chk(xfer_ok == 1, "R6", "ok at completion", xfer_ok, 1);
            chk(dreq == cfg_req_lo, "R6", "request idle at completion", dreq, cfg_req_lo);
        end
        #1;
        chk(exp_q.size() == 0, "R10", "all words strobed", exp_q.size(), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "ALL", "watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0, "R1", "busy", busy, 0);
        chk(dreq == 0, "R1", "dreq", dreq, 0);
        chk(xfer_ok == 0 && xfer_err == 0 && irq == 0, "R1", "status", {xfer_ok, xfer_err, irq}, 0);
        chk(ep_route == 0, "R1", "route", ep_route, 0);

        // R4 acknowledge in idle ignored
        dack = ack_lvl(1);
        #1;
        chk(!buf_push && !buf_pop, "R4", "idle acknowledge ignored", buf_push | buf_pop, 0);
        @(negedge clk);
        dack = ack_lvl(0);
        chk(busy == 0, "R4", "idle after stray acknowledge", busy, 0);

        // R3 R4 R7: 32-bit write, 16 bytes, bursts of 2
        run_xfer(16, 2, 1, 0, 3, -1, -1);
        chk(irq == 1, "R7", "irq with both enables", irq, 1);
        // R3 R4: 16-bit read, 10 bytes, bursts of 3 then 2
        run_xfer(10, 3, 0, 1, 5, -1, -1);
        // R4 toggle: burst of 1
        run_xfer(12, 1, 1, 0, 0, -1, -1);
        // R3 partial tail: 7 bytes on 32-bit bus
        run_xfer(7, 4, 1, 1, 7, -1, -1);

        // R5 inverted polarities, burst field 0
        @(negedge clk);
        cfg_req_lo = 1;
        cfg_ack_lo = 1;
        dack = 1;
        #1;
        chk(dreq == 1, "R5", "active-low request idles high", dreq, 1);
        run_xfer(8, 0, 0, 0, 2, -1, -1);
        @(negedge clk);
        cfg_req_lo = 0;
        cfg_ack_lo = 0;
        dack = 0;

        // R2 counter disabled: start ignored
        @(negedge clk);
        cfg_cnt_off = 1;
        cfg_byte_cnt = 8;
        cmd_wr_go = 1;
        @(negedge clk);
        cmd_wr_go = 0;
        chk(busy == 0, "R2", "start ignored with counter off", busy, 0);
        chk(xfer_ok == 1, "R2", "ok kept after ignored start", xfer_ok, 1);
        chk(dreq == 0, "R2", "no request with counter off", dreq, 0);
        cfg_cnt_off = 0;
        cfg_byte_cnt = 0;
        cmd_rd_go = 1;
        @(negedge clk);
        cmd_rd_go = 0;
        chk(busy == 0, "R2", "start ignored with zero count", busy, 0);

        // R8 collision at second cycle
        run_xfer(16, 4, 1, 0, 1, 1, -1);
        chk(xfer_err == 1, "R8", "error held after transfer", xfer_err, 1);

        // R9 abort after two cycles
        run_xfer(32, 2, 1, 0, 4, -1, 2);
        chk(irq == 0, "R9", "no irq after abort", irq, 0);

        // R7 DMA enable low masks irq
        ien_dma = 0;
        run_xfer(4, 1, 1, 1, 6, -1, -1);
        chk(irq == 0, "R7", "irq masked", irq, 0);
        ien_dma = 1;
        #1;
        chk(irq == 1, "R7", "irq after enabling", irq, 1);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule